// File: doc/BRIEF.md
# Line loss-of-signal detector

This block watches one received line and decides when its signal has been lost and when it has come back. Once per received bit interval a strobe arrives, together with two qualifiers from the analog front end. The first is a mark flag, which is high when a pulse was seen. The second is an amplitude flag, which is high when the pulse height is above the clear threshold. An interval with no mark counts as an interval below the declare threshold.

Loss is declared after a run of unmarked intervals. Loss is cleared only after a qualifying window of intervals has been seen. The window starts on a mark, keeps the amplitude high throughout, has no long run of zeros and has enough marks. The lengths and limits come from a line-rate input (T1 or E1) and a criterion-select input.

The block reports the loss status directly. It also keeps a latched interrupt status, which is set on a rising change of the loss status or on any change of it, as selected. Software clears that status with a write-one-to-clear strobe. A mask input gates the interrupt output.

Top module: `line_los_det`

## Requirements
- R1: After reset, `los`, `ists` and `irq` are all 0 and every internal count is zero.
- R2: While `los` is 0, `los` rises at the strobe that completes N consecutive strobes with `mark`=0. N is 175 for (`mode_e1`=0, `crit_sel`=0), 1544 for (0,1), 32 for (1,0) and 2048 for (1,1). A strobe with `mark`=1 restarts the count.
- R3: While `los` is 1, a clear window opens at a strobe with `mark`=1 and `amp_hi`=1. `los` falls at the window's M-th strobe, counting the opening one, if the window held at least ceil(M/8) marks. M is 175 with 22 marks for T1 (`mode_e1`=0) and 32 with 4 marks for E1 (`mode_e1`=1).
- R4: A run of zeros inside a clear window that reaches 100 (T1) or 16 (E1) ends the window. A run one shorter does not.
- R5: A window that reaches M strobes with too few marks ends without clearing.
- R6: A strobe with `amp_hi`=0 inside a window ends it. After a window ends for any reason, the next window opens only at a later strobe with `mark`=1 and `amp_hi`=1.
- R7: Cycles with `bit_stb`=0 change neither `los` nor any count, whatever `mark` and `amp_hi` are.
- R8: `ists` is set in the cycle `los` rises. With `edge_any`=1 it is also set in the cycle `los` falls.
- R9: `ists` stays 1 until a cycle with `ists_clr`=1. If a status event and `ists_clr` fall in the same cycle, `ists` stays 1.
- R10: `irq` is 1 exactly when `ists` is 1 and `irq_mask` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_stb | input | 1 | One pulse per received bit interval |
| mark | input | 1 | Pulse seen in this interval |
| amp_hi | input | 1 | Amplitude above the clear threshold in this interval |
| mode_e1 | input | 1 | 0 = T1 rules, 1 = E1 rules |
| crit_sel | input | 1 | Selects the declare length (see R2) |
| edge_any | input | 1 | 0 = status set on loss rise only, 1 = on either change |
| irq_mask | input | 1 | Masks the interrupt output |
| ists_clr | input | 1 | Write-one-to-clear for the interrupt status |
| los | output | 1 | Loss-of-signal status |
| ists | output | 1 | Latched interrupt status |
| irq | output | 1 | Interrupt request |

## Verification
The declare side is driven in all four rate and criterion settings with all-zero runs that stop one short of N and then reach it. A single mark placed mid-run shows that the count restarts.

On the clear side, four patterns are compared:
- one mark in eight, which just reaches the density limit;
- one mark in nine, which falls short;
- a run of zeros of exactly the limit, set against one a single interval shorter;
- a window broken by low amplitude.

Together these separate the density rule, the run limit, the amplitude rule and the rule that a window opens only on a mark. Idle cycles with a busy mark input show that only strobed intervals count. Masking, the clear strobe and a clear strobe coinciding with a status event exercise the interrupt path.

// File: rtl/line_los_det.sv
module line_los_det #(
  parameter int T1_DECL_STD = 175,
  parameter int T1_DECL_ALT = 1544,
  parameter int E1_DECL_STD = 32,
  parameter int E1_DECL_ALT = 2048,
  parameter int T1_WIN      = 175,
  parameter int E1_WIN      = 32,
  parameter int T1_ZLIM     = 100,
  parameter int E1_ZLIM     = 16,
  parameter int CW          = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic mark,
  input  logic amp_hi,
  input  logic mode_e1,
  input  logic crit_sel,
  input  logic edge_any,
  input  logic irq_mask,
  input  logic ists_clr,
  output logic los,
  output logic ists,
  output logic irq
);
  localparam logic [CW-1:0] T1_DMIN = CW'((T1_WIN + 7) / 8);
  localparam logic [CW-1:0] E1_DMIN = CW'((E1_WIN + 7) / 8);

  logic [CW-1:0] zrun, wlen, wmarks;
  logic          win_on;

  wire [CW-1:0] n_decl = mode_e1 ? (crit_sel ? CW'(E1_DECL_ALT) : CW'(E1_DECL_STD))
                                 : (crit_sel ? CW'(T1_DECL_ALT) : CW'(T1_DECL_STD));
  wire [CW-1:0] m_win  = mode_e1 ? CW'(E1_WIN)  : CW'(T1_WIN);
  wire [CW-1:0] d_min  = mode_e1 ? E1_DMIN      : T1_DMIN;
  wire [CW-1:0] z_lim  = mode_e1 ? CW'(E1_ZLIM) : CW'(T1_ZLIM);

  wire [CW-1:0] zrun_nx   = mark ? '0 : ((&zrun) ? zrun : zrun + 1'b1);
  wire [CW-1:0] wlen_nx   = wlen + 1'b1;
  wire [CW-1:0] wmarks_nx = wmarks + {{(CW-1){1'b0}}, mark};

  wire z_viol  = !mark && (zrun_nx >= z_lim);
  wire w_break = win_on && (!amp_hi || z_viol);
  wire w_start = !win_on && mark && amp_hi;
  wire w_end   = win_on && !w_break && (wlen_nx >= m_win);
  wire decl    = !los && !mark && (zrun_nx >= n_decl);
  wire clr_ok  = los && w_end && (wmarks_nx >= d_min);

  wire los_nx  = !bit_stb ? los : (decl ? 1'b1 : (clr_ok ? 1'b0 : los));
  wire ev      = edge_any ? (los_nx != los) : (los_nx && !los);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zrun   <= '0;
      wlen   <= '0;
      wmarks <= '0;
      win_on <= 1'b0;
      los    <= 1'b0;
    end else if (bit_stb) begin
      zrun <= zrun_nx;
      los  <= los_nx;
      if (!los || w_break || w_end) begin
        win_on <= 1'b0;
        wlen   <= '0;
        wmarks <= '0;
      end else if (w_start) begin
        win_on <= 1'b1;
        wlen   <= {{(CW-1){1'b0}}, 1'b1};
        wmarks <= {{(CW-1){1'b0}}, 1'b1};
      end else if (win_on) begin
        wlen   <= wlen_nx;
        wmarks <= wmarks_nx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ists <= 1'b0;
    else if (ev)       ists <= 1'b1;
    else if (ists_clr) ists <= 1'b0;
  end

  assign irq = ists & ~irq_mask;
endmodule

module line_los_det_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_stb,
  input logic mark,
  input logic amp_hi,
  input logic irq_mask,
  input logic ists_clr,
  input logic los,
  input logic ists,
  input logic irq
);
  AST_LOS_NEEDS_STB: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> $stable(los)); // R7
  AST_DECL_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los) |-> $past(bit_stb && !mark)); // R2
  AST_CLR_ON_AMP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(los) |-> $past(bit_stb && amp_hi)); // R3
  AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los) |-> ists); // R8
  AST_ISTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ists && !ists_clr) |=> ists); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask |-> !irq); // R10
  AST_IRQ_NEEDS_ISTS: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ists); // R10
endmodule

bind line_los_det line_los_det_chk u_chk (.*);

// File: tb/line_los_det_tb.sv
module line_los_det_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_stb = 0, mark = 0, amp_hi = 0, mode_e1 = 0, crit_sel = 0;
  logic edge_any = 0, irq_mask = 0, ists_clr = 0;
  logic los, ists, irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit m_los = 0, m_ists = 0;
  int m_zeros = 0, m_wlen = 0, m_wmarks = 0;
  bit m_win = 0;

  always #4 clk = ~clk;

  line_los_det u_dut (.*);

  function automatic int decl_len();
    if (mode_e1) return crit_sel ? 2048 : 32;
    return crit_sel ? 1544 : 175;
  endfunction

  task automatic model_tick();
    bit old = m_los;
    bit nxt = m_los;
    if (bit_stb) begin
      int win_m = mode_e1 ? 32 : 175;
      int zl = mode_e1 ? 16 : 100;
      int need = (win_m + 7) / 8;
      m_zeros = mark ? 0 : m_zeros + 1;
      if (!m_los) begin
        m_win = 0; m_wlen = 0; m_wmarks = 0;
        if (m_zeros >= decl_len()) nxt = 1;
      end else if (m_win) begin
        if (!amp_hi || (!mark && m_zeros >= zl)) begin
          m_win = 0; m_wlen = 0; m_wmarks = 0;
        end else begin
          m_wlen++;
          if (mark) m_wmarks++;
          if (m_wlen >= win_m) begin
            if (m_wmarks >= need) nxt = 0;
            m_win = 0; m_wlen = 0; m_wmarks = 0;
          end
        end
      end else if (mark && amp_hi) begin
        m_win = 1; m_wlen = 1; m_wmarks = 1;
      end
    end
    m_los = nxt;
    if ((nxt && !old) || (edge_any && (nxt != old))) m_ists = 1;
    else if (ists_clr) m_ists = 0;
  endtask

  task automatic chk(input bit got, input bit exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %b expected %b", cur_req, what, got, exp);
    end
  endtask

  task automatic step(input bit s, input bit m, input bit a, input bit c);
    @(negedge clk);
    bit_stb = s; mark = m; amp_hi = a; ists_clr = c;
    @(posedge clk);
    model_tick();
    #1;
    chk(los, m_los, "los vs model");
    chk(ists, m_ists, "ists vs model");
    chk(irq, m_ists && !irq_mask, "irq vs model");
  endtask

  task automatic zeros(input int n, input bit a);
    for (int i = 0; i < n; i++) step(1, 0, a, 0);
  endtask

  task automatic ones(input int n);
    for (int i = 0; i < n; i++) step(1, 1, 1, 0);
  endtask

  task automatic pat(input int n, input int per);
    for (int i = 0; i < n; i++) step(1, (i % per) == 0, 1, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1600000;
    errors++;
    checks++;
    $display("FAIL watchdog expired los=%b expected run end", los);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    cur_req = "R1";
    chk(los, 0, "los after reset"); chk(ists, 0, "ists after reset"); chk(irq, 0, "irq after reset");

    cur_req = "R2";
    zeros(174, 0); chk(los, 0, "T1 std 174 zeros");
    zeros(1, 0);   chk(los, 1, "T1 std 175 zeros");
    cur_req = "R8";  chk(ists, 1, "set on rise");
    cur_req = "R10"; chk(irq, 1, "irq unmasked");
    irq_mask = 1; step(0, 0, 0, 0); chk(irq, 0, "irq masked");
    irq_mask = 0;
    cur_req = "R9"; step(0, 0, 0, 1); chk(ists, 0, "w1c clears");

    cur_req = "R5"; pat(175, 9); chk(los, 1, "20 marks do not clear");
    cur_req = "R3"; pat(174, 8); chk(los, 1, "window not complete");
    step(1, 0, 1, 0); chk(los, 0, "22 marks clear T1");
    cur_req = "R8"; chk(ists, 0, "fall ignored edge_any=0");

    cur_req = "R2"; zeros(100, 0); step(1, 1, 1, 0); zeros(174, 0);
    chk(los, 0, "mark restarts count");
    zeros(1, 0); chk(los, 1, "declare after restart");

    mode_e1 = 1; edge_any = 1;
    cur_req = "R4"; step(1, 1, 1, 0); zeros(16, 1); ones(15);
    chk(los, 1, "16-zero run breaks window");
    ones(16); chk(los, 1, "restarted window not done");
    ones(1);  chk(los, 0, "restarted window clears");
    cur_req = "R8"; chk(ists, 1, "fall sets with edge_any=1");

    cur_req = "R2"; zeros(32, 0); chk(los, 1, "E1 std 32 zeros");
    step(0, 0, 0, 1);
    cur_req = "R4"; step(1, 1, 1, 0); zeros(15, 1); ones(15);
    chk(los, 1, "15-zero window incomplete");
    ones(1); chk(los, 0, "15-zero run tolerated");

    zeros(32, 0);
    cur_req = "R6"; ones(10); step(1, 1, 0, 0); ones(21);
    chk(los, 1, "low amplitude breaks window");
    ones(10); chk(los, 1, "restart window not done");
    ones(1);  chk(los, 0, "clear after amplitude restart");

    cur_req = "R7"; zeros(31, 0);
    for (int i = 0; i < 50; i++) step(0, i % 2, 1, 0);
    chk(los, 0, "idle cycles ignored");
    zeros(1, 0); chk(los, 1, "count resumes after idle");

    cur_req = "R9"; step(0, 0, 0, 1); chk(ists, 0, "cleared before race");
    ones(31); step(1, 1, 1, 1); chk(los, 0, "clear in race cycle");
    chk(ists, 1, "event beats w1c");

    cur_req = "R2"; crit_sel = 1;
    zeros(2047, 0); chk(los, 0, "E1 alt 2047 zeros");
    zeros(1, 0);    chk(los, 1, "E1 alt 2048 zeros");
    mode_e1 = 0;
    cur_req = "R3"; ones(175); chk(los, 0, "T1 all-mark clear");
    cur_req = "R2"; zeros(1543, 0); chk(los, 0, "T1 alt 1543 zeros");
    zeros(1, 0);    chk(los, 1, "T1 alt 1544 zeros");

    finish_run();
  end
endmodule